// File: doc/BRIEF.md
# Instruction Template Queue with Destination Search

This block is the holding queue between the decode side and the execute side of a short processor pipeline. Decode pushes one decoded instruction template per cycle, and execute inspects and pops the oldest template. Each template is one of four kinds:

- **add:** a destination register and two operand values.
- **branch-if-zero:** a condition value and a target address.
- **load:** a destination register and a data address.
- **store:** a data value and an address.

The queue offers a single-cycle flush. Execute uses it when a branch is taken, so that every younger queued template is thrown away at once.

Next to the ordinary queue ports there is a combinational lookup. Decode presents a register number, and the block answers whether any template still held in the queue will write that register. Only add and load templates name a destination. Decode combines this answer with the source registers of the instruction it is about to issue and stalls on a read-after-write hazard. The lookup sees the queue contents as they stand before the coming clock edge.

Top module: `tmpl_queue`

## Requirements
- R1: After reset the queue is empty: `empty` is 1, `full` is 0, and `find_hit` is 0 for every key.
- R2: A push accepted while `full` is 0 stores the template. `head_data` always shows the oldest stored template, and templates leave in the order they arrived.
- R3: A push requested while `full` is 1 is ignored. The stored templates and their order do not change, and the rejected template's destination never produces a hit.
- R4: A pop requested while `empty` is 1 is ignored. The queue stays empty, and a later push behaves normally.
- R5: `full` and `empty` are registered. They take their new values in the same clock edge that changes the occupancy, and `full` is 1 exactly when DEPTH templates are held.
- R6: `find_hit` is 1 when a held add or load template has a destination field equal to `find_reg`, and 0 otherwise.
- R7: Branch and store templates never produce a hit, whatever value bits [68:64] hold.
- R8: Slots that were never filled, or that have been popped, never produce a hit. `find_hit` reflects the contents before any push or pop of the current cycle.
- R9: Asserting `flush` empties the queue at the next edge. It takes priority over a push or pop in the same cycle.
- R10: A push and a pop in the same cycle on a queue that is neither empty nor full leave the occupancy unchanged and advance the head.
- R11: A template is 71 bits wide:
  - The kind sits in bits [70:69]: 00 add, 01 branch, 10 load, 11 store.
  - The destination register sits in bits [68:64].
  - The first value sits in bits [63:32] and the second value in bits [31:0].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| push | input | 1 | Push request for `push_data` |
| push_data | input | 71 | Template to store |
| pop | input | 1 | Remove the oldest template |
| flush | input | 1 | Discard every held template |
| head_data | output | 71 | Oldest held template |
| full | output | 1 | Queue holds DEPTH templates |
| empty | output | 1 | Queue holds no template |
| find_reg | input | 5 | Register number to look up |
| find_hit | output | 1 | A held add or load template writes `find_reg` |

## Verification
The assertions take the control inputs `push`, `pop` and `flush` to be known (never X or Z) at every sampled edge once reset has been released. They also take `rst_n` to be the only source of reset. No other assumption is made about the callers: requests against a full or an empty queue are legal, and the design must absorb them. The stimulus changes every input one time unit after a rising edge and holds it steady through the next edge. Requests are kept at 0 whenever no scenario drives them, so the control inputs are always defined while the checks are running.

// File: rtl/tq_pkg.sv
package tq_pkg;
  localparam int REG_W = 5;
  localparam int VAL_W = 32;
  localparam int KIND_W = 2;
  localparam int PAY_W = REG_W + 2 * VAL_W;
  localparam int ENT_W = KIND_W + PAY_W;
  localparam int KIND_LSB = PAY_W;
  localparam int DST_LSB = 2 * VAL_W;
  localparam int TAG_W = KIND_W + REG_W;

  typedef enum logic [KIND_W-1:0] {
    KIND_ADD = 2'b00,
    KIND_BRZ = 2'b01,
    KIND_LD  = 2'b10,
    KIND_ST  = 2'b11
  } kind_e;

  function automatic logic names_dest(input logic [KIND_W-1:0] k);
    return (kind_e'(k) == KIND_ADD) || (kind_e'(k) == KIND_LD);
  endfunction
endpackage

// File: rtl/tq_ctrl.sv
module tq_ctrl #(
  parameter int DEPTH = 2,
  parameter int PW = 1,
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_req,
  input  logic          pop_req,
  input  logic          flush,
  output logic          wr_fire,
  output logic          rd_fire,
  output logic [PW-1:0] wr_ptr,
  output logic [PW-1:0] rd_ptr,
  output logic [CW-1:0] occ,
  output logic          full,
  output logic          empty
);
  logic [PW-1:0] wr_ptr_d, rd_ptr_d;
  logic [CW-1:0] occ_d;
  logic          full_d, empty_d;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wr_fire  = push_req && !full && !flush;
    rd_fire  = pop_req && !empty && !flush;
    wr_ptr_d = wr_ptr;
    rd_ptr_d = rd_ptr;
    occ_d    = occ;
    if (flush) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      occ_d    = '0;
    end else begin
      if (wr_fire) wr_ptr_d = bump(wr_ptr);
      if (rd_fire) rd_ptr_d = bump(rd_ptr);
      case ({wr_fire, rd_fire})
        2'b10:   occ_d = occ + 1'b1;
        2'b01:   occ_d = occ - 1'b1;
        default: occ_d = occ;
      endcase
    end
    full_d  = (occ_d == CW'(DEPTH));
    empty_d = (occ_d == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ    <= '0;
      full   <= 1'b0;
      empty  <= 1'b1;
    end else begin
      wr_ptr <= wr_ptr_d;
      rd_ptr <= rd_ptr_d;
      occ    <= occ_d;
      full   <= full_d;
      empty  <= empty_d;
    end
  end

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push_req && !pop_req && !flush) |=> (full && $stable(occ)));

  p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop_req && !push_req && !flush) |=> empty);

  p_flags_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));

  p_flush_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (empty && !full && occ == '0));

  p_swap_keeps_occ_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && pop_req && !full && !empty && !flush) |=> $stable(occ));
endmodule

// File: rtl/tq_store.sv
module tq_store #(
  parameter int DEPTH = 2,
  parameter int PW = 1,
  parameter int W = 71,
  parameter int TW = 7
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_fire,
  input  logic [PW-1:0]            wr_ptr,
  input  logic [W-1:0]             wr_data,
  input  logic                     rd_fire,
  input  logic [PW-1:0]            rd_ptr,
  input  logic                     flush,
  output logic [W-1:0]             rd_data,
  output logic [DEPTH-1:0]         live,
  output logic [DEPTH-1:0][TW-1:0] slot_tag
);
  logic [DEPTH-1:0][W-1:0] mem;
  logic [DEPTH-1:0]        live_d;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic sel_wr, sel_rd;
    assign sel_wr = wr_fire && (wr_ptr == PW'(i));
    assign sel_rd = rd_fire && (rd_ptr == PW'(i));

    always_ff @(posedge clk) begin
      if (sel_wr) mem[i] <= wr_data;
    end

    always_comb begin
      if (flush)       live_d[i] = 1'b0;
      else if (sel_wr) live_d[i] = 1'b1;
      else if (sel_rd) live_d[i] = 1'b0;
      else             live_d[i] = live[i];
    end

    assign slot_tag[i] = mem[i][W-1 -: TW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live <= '0;
    else        live <= live_d;
  end

  assign rd_data = mem[rd_ptr];
endmodule

// File: rtl/tq_search.sv
module tq_search
  import tq_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic [DEPTH-1:0]            live,
  input  logic [DEPTH-1:0][TAG_W-1:0] slot_tag,
  input  logic [REG_W-1:0]            key,
  output logic                        hit
);
  logic [DEPTH-1:0] slot_hit;

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    logic [KIND_W-1:0] kind;
    logic [REG_W-1:0]  dst;
    assign kind = slot_tag[i][TAG_W-1 -: KIND_W];
    assign dst  = slot_tag[i][REG_W-1:0];
    assign slot_hit[i] = live[i] && names_dest(kind) && (dst == key);
  end

  assign hit = |slot_hit;
endmodule

// File: rtl/tmpl_queue.sv
module tmpl_queue
  import tq_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [ENT_W-1:0] push_data,
  input  logic             pop,
  input  logic             flush,
  output logic [ENT_W-1:0] head_data,
  output logic             full,
  output logic             empty,
  input  logic [REG_W-1:0] find_reg,
  output logic             find_hit
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [1:0]                  rst_pipe;
  logic                        rst_s_n;
  logic                        wr_fire, rd_fire;
  logic [PW-1:0]               wr_ptr, rd_ptr;
  logic [CW-1:0]               occ;
  logic [DEPTH-1:0]            live;
  logic [DEPTH-1:0][TAG_W-1:0] slot_tag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s_n = rst_pipe[1];

  tq_ctrl #(.DEPTH(DEPTH), .PW(PW), .CW(CW)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .push_req (push),
    .pop_req  (pop),
    .flush    (flush),
    .wr_fire  (wr_fire),
    .rd_fire  (rd_fire),
    .wr_ptr   (wr_ptr),
    .rd_ptr   (rd_ptr),
    .occ      (occ),
    .full     (full),
    .empty    (empty)
  );

  tq_store #(.DEPTH(DEPTH), .PW(PW), .W(ENT_W), .TW(TAG_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .wr_fire  (wr_fire),
    .wr_ptr   (wr_ptr),
    .wr_data  (push_data),
    .rd_fire  (rd_fire),
    .rd_ptr   (rd_ptr),
    .flush    (flush),
    .rd_data  (head_data),
    .live     (live),
    .slot_tag (slot_tag)
  );

  tq_search #(.DEPTH(DEPTH)) u_search (
    .live     (live),
    .slot_tag (slot_tag),
    .key      (find_reg),
    .hit      (find_hit)
  );

  p_live_matches_occ_r2: assert property (@(posedge clk) disable iff (!rst_s_n)
    $countones(live) == int'(occ));

  p_no_hit_when_idle_r8: assert property (@(posedge clk) disable iff (!rst_s_n)
    (live == '0) |-> !find_hit);

  p_empty_tracks_live_r5: assert property (@(posedge clk) disable iff (!rst_s_n)
    empty == (live == '0));
endmodule

// File: tb/tmpl_queue_tb.sv
module tmpl_queue_tb;
  import tq_pkg::*;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             push = 1'b0;
  logic [ENT_W-1:0] push_data = '0;
  logic             pop = 1'b0;
  logic             flush = 1'b0;
  logic [REG_W-1:0] find_reg = '0;
  logic [ENT_W-1:0] head_data;
  logic             full, empty, find_hit;
  int               n_run = 0;
  int               n_fail = 0;

  always #5 clk = ~clk;

  tmpl_queue #(.DEPTH(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .push(push), .push_data(push_data),
    .pop(pop), .flush(flush), .head_data(head_data), .full(full),
    .empty(empty), .find_reg(find_reg), .find_hit(find_hit)
  );

  function automatic logic [ENT_W-1:0] mk(input logic [1:0] k, input logic [4:0] d,
                                          input logic [31:0] a, input logic [31:0] b);
    return {k, d, a, b};
  endfunction

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic do_push(input logic [ENT_W-1:0] d);
    push = 1'b1; push_data = d;
    cyc();
    push = 1'b0;
  endtask

  task automatic do_pop();
    pop = 1'b1;
    cyc();
    pop = 1'b0;
  endtask

  task automatic probe(input string req, input logic [4:0] r, input logic exp);
    find_reg = r;
    #1;
    chk(req, find_hit, exp);
  endtask

  task automatic t_reset();
    chk("R1 empty", empty, 1'b1);
    chk("R1 full", full, 1'b0);
    for (int r = 0; r < 32; r += 7) probe("R1 hit", 5'(r), 1'b0);
  endtask

  task automatic t_order();
    logic [ENT_W-1:0] a, b;
    a = mk(2'b00, 5'd3, 32'h1111_0001, 32'h2222_0002);
    b = mk(2'b10, 5'd7, 32'h0, 32'hABCD_0040);
    do_push(a);
    chk("R5 not full after one", full, 1'b0);
    chk("R5 not empty after one", empty, 1'b0);
    do_push(b);
    chk("R5 full at depth", full, 1'b1);
    chk("R2 head oldest", head_data, a);
    probe("R6 add dst", 5'd3, 1'b1);
    probe("R6 load dst", 5'd7, 1'b1);
    probe("R6 miss", 5'd4, 1'b0);
    do_pop();
    chk("R2 head second", head_data, b);
    chk("R5 full clears", full, 1'b0);
    probe("R8 popped slot", 5'd3, 1'b0);
    do_pop();
    chk("R5 empty after drain", empty, 1'b1);
    probe("R8 all popped", 5'd7, 1'b0);
  endtask

  task automatic t_overflow();
    logic [ENT_W-1:0] a, b, c;
    a = mk(2'b00, 5'd1, 32'hA, 32'hB);
    b = mk(2'b00, 5'd2, 32'hC, 32'hD);
    c = mk(2'b10, 5'd9, 32'h0, 32'hE);
    do_push(a);
    do_push(b);
    do_push(c);
    chk("R3 still full", full, 1'b1);
    chk("R3 head kept", head_data, a);
    probe("R3 rejected dst", 5'd9, 1'b0);
    do_pop();
    chk("R3 second kept", head_data, b);
    do_pop();
    chk("R3 nothing extra", empty, 1'b1);
  endtask

  task automatic t_underflow();
    logic [ENT_W-1:0] a;
    a = mk(2'b10, 5'd12, 32'h0, 32'h77);
    do_pop();
    chk("R4 stays empty", empty, 1'b1);
    chk("R4 not full", full, 1'b0);
    do_push(a);
    chk("R4 head after push", head_data, a);
    chk("R4 not empty", empty, 1'b0);
    chk("R4 single entry", full, 1'b0);
    do_pop();
    chk("R4 drained", empty, 1'b1);
  endtask

  task automatic t_no_dest();
    logic [ENT_W-1:0] br, st;
    br = mk(2'b01, 5'd9, 32'h0, 32'h100);
    st = mk(2'b11, 5'd9, 32'h55, 32'h200);
    do_push(br);
    do_push(st);
    probe("R7 branch/store no hit", 5'd9, 1'b0);
    chk("R11 branch kind at head", head_data[70:69], 2'b01);
    do_pop();
    chk("R11 store kind at head", head_data[70:69], 2'b11);
    probe("R7 store alone", 5'd9, 1'b0);
    do_pop();
  endtask

  task automatic t_swap();
    logic [ENT_W-1:0] a, b;
    a = mk(2'b00, 5'd5, 32'h1, 32'h2);
    b = mk(2'b00, 5'd6, 32'h3, 32'h4);
    do_push(a);
    push = 1'b1; push_data = b; pop = 1'b1;
    probe("R8 pre-edge no new", 5'd6, 1'b0);
    probe("R8 pre-edge old", 5'd5, 1'b1);
    cyc();
    push = 1'b0; pop = 1'b0;
    chk("R10 head advanced", head_data, b);
    chk("R10 occupancy one", full, 1'b0);
    chk("R10 not empty", empty, 1'b0);
    probe("R10 old gone", 5'd5, 1'b0);
    probe("R10 new found", 5'd6, 1'b1);
    do_pop();
    chk("R10 drained", empty, 1'b1);
  endtask

  task automatic t_flush();
    logic [ENT_W-1:0] a, b, c;
    a = mk(2'b00, 5'd20, 32'h1, 32'h1);
    b = mk(2'b10, 5'd21, 32'h0, 32'h8);
    c = mk(2'b00, 5'd22, 32'h9, 32'h9);
    do_push(a);
    do_push(b);
    flush = 1'b1; push = 1'b1; push_data = c; pop = 1'b1;
    cyc();
    flush = 1'b0; push = 1'b0; pop = 1'b0;
    chk("R9 empty after flush", empty, 1'b1);
    chk("R9 not full", full, 1'b0);
    probe("R9 old dst gone", 5'd20, 1'b0);
    probe("R9 push dropped", 5'd22, 1'b0);
    do_push(c);
    chk("R9 fresh head", head_data, c);
    do_pop();
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) cyc();
    t_reset();
    t_order();
    t_overflow();
    t_underflow();
    t_no_dest();
    t_swap();
    t_flush();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule